// File: doc/BRIEF.md
# Biphase-Mark Consumer Audio Transmitter

This block turns a stream of two-channel 24-bit audio samples into a single-wire consumer digital-audio line signal. Each frame carries a left and a right subframe. A subframe holds a 4-slot synchronisation preamble, the 24-bit sample, a validity flag, one user-data bit, one channel-status bit and an even-parity bit. The data slots are biphase-mark coded on the wire, and the preambles deliberately break that coding so a receiver can find them.

Channel-status and user-data bits come from two 384-bit tables. Each table is split into a left half and a right half of six 32-bit words. Frame n of a 192-frame block sends bit n of each channel's half: word n/32, bit n%32. A simple word-write port fills the tables. The line advances by one half-cell on each pulse of a cell-rate enable, which runs at twice the bit rate and is supplied from outside. A control input turns the transmitter on. While it is off the line rests low and the block position goes back to its start.

Top module: `dai_tx`

## Requirements
- R1: While `tx_enable` is low, or during reset, `txd` is 0 and the position returns to the start. The first subframe after `tx_enable` rises is the left subframe of frame 0.
- R2: A subframe is 64 half-cells (32 slots × 2). `txd` changes only in a cycle where `cell_en` is high, and each such cycle emits the next half-cell.
- R3: Preambles use these half-cell patterns, first half-cell first, for a previous line level of 0: B = 11101000, M = 11100010, W = 11100100. B is used for the left subframe of frame 0, M for every other left subframe and W for every right subframe. If the previous level was 1, the pattern is inverted, so the first preamble half-cell always differs from the level before it.
- R4: Slots 4..27 carry the 24-bit sample, LSB first. The left subframe uses `left_sample` and the right subframe uses `right_sample`, each captured at the first half-cell of its subframe.
- R5: Slot 28 carries the channel's invalid flag (`left_invalid` / `right_invalid`), captured with the sample.
- R6: Slot 29 carries user bit n of the channel's user half for frame n: word n/32, bit n%32.
- R7: Slot 30 carries channel-status bit n of the channel's status half, indexed the same way.
- R8: Slot 31 is a parity bit that makes the count of ones in slots 4..31 even.
- R9: Each data slot (4..31) starts with a level change. It has a second change at mid-slot exactly when the bit is 1.
- R10: After frame 191 the block wraps to frame 0, which again starts with preamble B.
- R11: A table write uses `tbl_wr_user` to pick the table (0 = status, 1 = user), `tbl_wr_right` to pick the half (0 = left, 1 = right) and `tbl_wr_word` to pick the word (0..5). Word indices 6 and 7 are ignored.
- R12: `sample_take` is high in exactly those cycles where `cell_en` is high, the block is enabled and the next half-cell is the first of a subframe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Transmitter on; when low the line idles low |
| cell_en | input | 1 | Half-cell advance strobe (twice the bit rate) |
| left_sample | input | 24 | Left audio sample |
| right_sample | input | 24 | Right audio sample |
| left_invalid | input | 1 | Validity flag sent with the left sample |
| right_invalid | input | 1 | Validity flag sent with the right sample |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_user | input | 1 | Table select: 0 status, 1 user |
| tbl_wr_right | input | 1 | Half select: 0 left, 1 right |
| tbl_wr_word | input | 3 | Word index within the half (0..5 valid) |
| tbl_wr_data | input | 32 | Word to store |
| sample_take | output | 1 | Samples are captured in this cycle |
| txd | output | 1 | Biphase-mark coded line output |

## Verification
The hardest points to reach from the ports are the block wrap from frame 191 to frame 0, and the status and user bits in the upper table words, because they appear only after some 24,000 half-cells. The stimulus reaches them by running the half-cell strobe every cycle after a short stretch at a slower rate. A model in the bench decodes every subframe from the line and checks it against its own copy of the tables. A write to an out-of-range word is made before enabling, so a wrong alias would show up as corrupted status bits in frames 0..31. Dropping the enable in mid-subframe and raising it again checks the idle level and the restart on preamble B.

// File: rtl/dai_tx_pkg.sv
package dai_tx_pkg;
    localparam int SAMPLE_W     = 24;
    localparam int WORD_W       = 32;
    localparam int STORE_WORDS  = 6;
    localparam int WADDR_W      = $clog2(STORE_WORDS);
    localparam int BLOCK_FRAMES = STORE_WORDS * WORD_W;
    localparam int FRAME_W      = $clog2(BLOCK_FRAMES);
    localparam int SLOTS        = 32;
    localparam int HALF_W       = $clog2(2 * SLOTS);
    localparam int PAY_W        = SAMPLE_W + 4;

    typedef enum logic [1:0] {PRE_B, PRE_M, PRE_W} pre_kind_t;

    // Half-cell patterns, first half-cell in bit 7, for a previous level of 0
    localparam logic [7:0] PAT_B = 8'b1110_1000;
    localparam logic [7:0] PAT_M = 8'b1110_0010;
    localparam logic [7:0] PAT_W = 8'b1110_0100;

    // Bit 0 goes out in slot 4, bit PAY_W-1 in slot 31
    typedef struct packed {
        logic                parity;
        logic                cstat;
        logic                user;
        logic                invalid;
        logic [SAMPLE_W-1:0] audio;
    } payload_t;

    function automatic logic pre_half(pre_kind_t kind, logic [2:0] idx);
        logic [7:0] pat;
        case (kind)
            PRE_B:   pat = PAT_B;
            PRE_M:   pat = PAT_M;
            default: pat = PAT_W;
        endcase
        return pat[3'd7 - idx];
    endfunction

    function automatic payload_t make_payload(logic [SAMPLE_W-1:0] audio,
                                              logic invalid, logic user, logic cstat);
        payload_t p;
        p.audio   = audio;
        p.invalid = invalid;
        p.user    = user;
        p.cstat   = cstat;
        p.parity  = ^{cstat, user, invalid, audio};
        return p;
    endfunction
endpackage

// File: rtl/dai_bit_store.sv
module dai_bit_store #(
    parameter int WORDS   = 6,
    parameter int WORD_W  = 32,
    localparam int ADDR_W = $clog2(WORDS),
    localparam int BITS   = WORDS * WORD_W,
    localparam int IDX_W  = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_right,
    input  logic [ADDR_W-1:0] wr_word,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [1:0]        rd_bits
);
    for (genvar c = 0; c < 2; c++) begin : g_half
        logic [BITS-1:0] bits_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q <= '0;
            end else if (wr_en && (wr_right == 1'(c)) && (int'(wr_word) < WORDS)) begin
                bits_q[int'(wr_word) * WORD_W +: WORD_W] <= wr_data;
            end
        end

        assign rd_bits[c] = bits_q[rd_idx];
    end
endmodule

// File: rtl/dai_frame_seq.sv
module dai_frame_seq #(
    parameter int FRAMES   = 192,
    parameter int HALVES   = 64,
    localparam int FRAME_W = $clog2(FRAMES),
    localparam int HALF_W  = $clog2(HALVES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               cell_en,
    output logic [HALF_W-1:0]  half,
    output logic [FRAME_W-1:0] frame,
    output logic               right,
    output logic               sub_start
);
    localparam logic [HALF_W-1:0]  LAST_HALF  = HALF_W'(HALVES - 1);
    localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(FRAMES - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            half  <= '0;
            frame <= '0;
            right <= 1'b0;
        end else if (cell_en) begin
            half <= half + 1'b1;
            if (half == LAST_HALF) begin
                right <= ~right;
                if (right) frame <= (frame == LAST_FRAME) ? '0 : frame + 1'b1;
            end
        end
    end

    assign sub_start = run && cell_en && (half == '0);

    AST_BLOCK_WRAP: assert property (@(posedge clk) disable iff (rst)
        run && cell_en && right && half == LAST_HALF && frame == LAST_FRAME
        |=> frame == '0 && !right && half == '0); // R10
    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (rst)
        frame <= LAST_FRAME); // R10
endmodule

// File: rtl/dai_bmc_enc.sv
module dai_bmc_enc
    import dai_tx_pkg::*;
#(
    parameter int HALVES  = 64,
    localparam int HALF_W = $clog2(HALVES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              cell_en,
    input  logic [HALF_W-1:0] half,
    input  pre_kind_t         kind_in,
    input  payload_t          payload_in,
    output logic              line
);
    payload_t            word_q;
    pre_kind_t           kind_q;
    logic                pol_q;
    logic [PAY_W-1:0]    word_bits;
    logic [HALF_W-2:0]   slot;

    assign word_bits = word_q;
    assign slot      = half[HALF_W-1:1];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            line   <= 1'b0;
            pol_q  <= 1'b0;
            word_q <= '0;
            kind_q <= PRE_B;
        end else if (cell_en) begin
            if (half == '0) begin
                word_q <= payload_in;
                kind_q <= kind_in;
                pol_q  <= line;
                line   <= pre_half(kind_in, 3'd0) ^ line;
            end else if (half < HALF_W'(8)) begin
                line <= pre_half(kind_q, half[2:0]) ^ pol_q;
            end else if (!half[0]) begin
                line <= ~line;
            end else begin
                line <= line ^ word_bits[slot - (HALF_W - 1)'(4)];
            end
        end
    end

    AST_CELL_EDGE: assert property (@(posedge clk) disable iff (rst)
        run && cell_en && half >= HALF_W'(8) && !half[0] |=> line != $past(line)); // R9
    AST_PRE_FLIP: assert property (@(posedge clk) disable iff (rst)
        run && cell_en && half == '0 |=> line != $past(line)); // R3
endmodule

// File: rtl/dai_tx.sv
module dai_tx
    import dai_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                tx_enable,
    input  logic                cell_en,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic [SAMPLE_W-1:0] right_sample,
    input  logic                left_invalid,
    input  logic                right_invalid,
    input  logic                tbl_wr_en,
    input  logic                tbl_wr_user,
    input  logic                tbl_wr_right,
    input  logic [WADDR_W-1:0]  tbl_wr_word,
    input  logic [WORD_W-1:0]   tbl_wr_data,
    output logic                sample_take,
    output logic                txd
);
    logic [HALF_W-1:0]  seq_half;
    logic [FRAME_W-1:0] seq_frame;
    logic               seq_right;
    logic [1:0]         cs_bits;
    logic [1:0]         user_bits;
    pre_kind_t          kind;
    payload_t           payload;

    dai_frame_seq #(.FRAMES(BLOCK_FRAMES), .HALVES(2 * SLOTS)) u_seq (
        .clk(clk), .rst(rst), .run(tx_enable), .cell_en(cell_en),
        .half(seq_half), .frame(seq_frame), .right(seq_right), .sub_start(sample_take)
    );

    dai_bit_store #(.WORDS(STORE_WORDS), .WORD_W(WORD_W)) u_cstat (
        .clk(clk), .rst(rst), .wr_en(tbl_wr_en && !tbl_wr_user),
        .wr_right(tbl_wr_right), .wr_word(tbl_wr_word), .wr_data(tbl_wr_data),
        .rd_idx(seq_frame), .rd_bits(cs_bits)
    );

    dai_bit_store #(.WORDS(STORE_WORDS), .WORD_W(WORD_W)) u_user (
        .clk(clk), .rst(rst), .wr_en(tbl_wr_en && tbl_wr_user),
        .wr_right(tbl_wr_right), .wr_word(tbl_wr_word), .wr_data(tbl_wr_data),
        .rd_idx(seq_frame), .rd_bits(user_bits)
    );

    assign kind    = seq_right ? PRE_W : ((seq_frame == '0) ? PRE_B : PRE_M);
    assign payload = make_payload(seq_right ? right_sample  : left_sample,
                                  seq_right ? right_invalid : left_invalid,
                                  user_bits[seq_right], cs_bits[seq_right]);

    dai_bmc_enc #(.HALVES(2 * SLOTS)) u_enc (
        .clk(clk), .rst(rst), .run(tx_enable), .cell_en(cell_en),
        .half(seq_half), .kind_in(kind), .payload_in(payload), .line(txd)
    );

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> !txd); // R1
    AST_HOLD_LINE: assert property (@(posedge clk) disable iff (rst)
        tx_enable && !cell_en |=> $stable(txd)); // R2
endmodule

// File: tb/dai_tx_tb.sv
module dai_tx_tb;
    import dai_tx_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1, tx_enable = 1'b0, cell_en = 1'b0;
    logic [23:0] left_sample = '0, right_sample = '0;
    logic        left_invalid = 1'b0, right_invalid = 1'b0;
    logic        tbl_wr_en = 1'b0, tbl_wr_user = 1'b0, tbl_wr_right = 1'b0;
    logic [2:0]  tbl_wr_word = '0;
    logic [31:0] tbl_wr_data = '0;
    logic        sample_take, txd;

    int total = 0, bad = 0;

    dai_tx u_dut (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .cell_en(cell_en),
        .left_sample(left_sample), .right_sample(right_sample),
        .left_invalid(left_invalid), .right_invalid(right_invalid),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_user(tbl_wr_user), .tbl_wr_right(tbl_wr_right),
        .tbl_wr_word(tbl_wr_word), .tbl_wr_data(tbl_wr_data),
        .sample_take(sample_take), .txd(txd)
    );

    // {div[1:0], left_invalid, right_invalid, left[23:0], right[23:0]}
    localparam int NVEC = 6;
    localparam logic [51:0] VEC [NVEC] = '{
        {2'd3, 1'b0, 1'b0, 24'h000000, 24'hFFFFFF},
        {2'd2, 1'b1, 1'b0, 24'h800001, 24'h7FFFFE},
        {2'd1, 1'b0, 1'b1, 24'h123456, 24'hABCDEF},
        {2'd3, 1'b1, 1'b1, 24'hAAAAAA, 24'h555555},
        {2'd1, 1'b0, 1'b0, 24'h000001, 24'h800000},
        {2'd2, 1'b1, 1'b0, 24'hF0F00F, 24'h0F0FF0}
    };

    logic [191:0] cs_m [2];
    logic [191:0] us_m [2];

    int   div = 1, cc = 0, hc = 0, fr = 0, ch = 0, sub_done = 0;
    bit   gen_on = 0, en_rec = 0, prev_lvl = 0, wrapped = 0;
    logic [63:0] hv;
    logic [23:0] cur_s;
    bit   cur_v;

    task automatic chk(bit ok, string req, longint got, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h (frame %0d ch %0d)", req, got, exp, fr, ch);
        end
    endtask

    task automatic check_sub();
        logic [7:0]  pat, got_pat, exp_pat;
        logic [27:0] got;
        bit          lvl, bmc_ok, u, c, par;
        pat = (ch == 1) ? PAT_W : ((fr == 0) ? PAT_B : PAT_M);
        for (int i = 0; i < 8; i++) begin
            got_pat[7-i] = hv[i];
            exp_pat[7-i] = pat[7-i] ^ prev_lvl;
        end
        if (fr == 0 && ch == 0 && wrapped)
            chk(got_pat == exp_pat, "R10 preamble after wrap", got_pat, exp_pat);
        else
            chk(got_pat == exp_pat, "R3 preamble", got_pat, exp_pat);
        lvl = hv[7];
        bmc_ok = 1;
        for (int s = 4; s < 32; s++) begin
            if (hv[2*s] == lvl) bmc_ok = 0;
            got[s-4] = hv[2*s] ^ hv[2*s+1];
            lvl = hv[2*s+1];
        end
        chk(bmc_ok, "R9 cell-start transition", bmc_ok, 1);
        u   = us_m[ch][fr];
        c   = cs_m[ch][fr];
        par = ^{c, u, cur_v, cur_s};
        chk(got[23:0] == cur_s, "R4 sample", got[23:0], cur_s);
        chk(got[24] == cur_v, "R5 validity", got[24], cur_v);
        chk(got[25] == u, "R6 user bit", got[25], u);
        chk(got[26] == c, "R7 status bit", got[26], c);
        chk(got[27] == par && ^got == 1'b0, "R8 parity", got[27], par);
    endtask

    // Half-cell strobe generation and line decoding
    initial forever begin
        @(negedge clk);
        if (cell_en && en_rec) begin
            hv[hc] = txd;
            hc++;
            if (hc == 64) begin
                check_sub();
                prev_lvl = hv[63];
                hc = 0;
                sub_done++;
                if (ch == 1) begin
                    fr = (fr == 191) ? 0 : fr + 1;
                    if (fr == 0) wrapped = 1;
                end
                ch ^= 1;
            end
        end
        en_rec = tx_enable && !rst;
        if (!en_rec) begin
            hc = 0; fr = 0; ch = 0; prev_lvl = 0;
        end
        if (gen_on) begin
            cell_en = (cc == 0);
            cc = (cc + 1 >= div) ? 0 : cc + 1;
        end else begin
            cell_en = 1'b0;
        end
        if (cell_en && en_rec && hc == 0) begin
            cur_s = ch ? right_sample  : left_sample;
            cur_v = ch ? right_invalid : left_invalid;
        end
        #1;
        if (en_rec && cell_en)
            chk(sample_take == (hc == 0), "R12 sample_take", sample_take, hc == 0);
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic wr_word(bit user, bit right, int w, logic [31:0] d);
        tick();
        tbl_wr_en = 1; tbl_wr_user = user; tbl_wr_right = right;
        tbl_wr_word = 3'(w); tbl_wr_data = d;
        tick();
        tbl_wr_en = 0;
        if (w < 6) begin
            if (user) us_m[right][w*32 +: 32] = d;
            else      cs_m[right][w*32 +: 32] = d;
        end
    endtask

    task automatic main_seq();
        int target;
        cs_m[0] = '0; cs_m[1] = '0; us_m[0] = '0; us_m[1] = '0;
        repeat (5) tick();
        @(negedge clk); #1;
        chk(txd == 0, "R1 reset line", txd, 0);
        chk(sample_take == 0, "R1 reset take", sample_take, 0);
        tick();
        rst = 0;
        for (int k = 0; k < 2; k++)
            for (int c = 0; c < 2; c++)
                for (int w = 0; w < 6; w++)
                    wr_word(k[0], c[0], w, 32'h9E3779B9 * 32'(w + 1 + 7*c + 13*k) ^ 32'(k*c*5));
        // R11: out-of-range word indices must not alias into words 0..5
        wr_word(0, 0, 6, 32'hFFFFFFFF);
        wr_word(1, 1, 7, 32'hFFFFFFFF);

        gen_on = 1;
        tick();
        tx_enable = 1;
        for (int v = 0; v < NVEC; v++) begin
            div           = int'(VEC[v][51:50]);
            left_invalid  = VEC[v][49];
            right_invalid = VEC[v][48];
            left_sample   = VEC[v][47:24];
            right_sample  = VEC[v][23:0];
            target = sub_done + 3;
            while (sub_done < target) tick();
        end

        // Run past the end of the block with changing samples (R4, R10)
        div = 1;
        while (!(wrapped && sub_done > 2 * 192 + 12)) begin
            tick();
            left_sample  = left_sample + 24'h013579;
            right_sample = right_sample ^ 24'h00A5C3 ^ {left_sample[10:0], 13'h0};
        end
        chk(wrapped, "R10 wrap seen", wrapped, 1);

        // Drop the enable mid-subframe (R1)
        repeat (17) tick();
        tx_enable = 0;
        tick();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); #2;
            chk(txd == 0, "R1 idle line", txd, 0);
            chk(sample_take == 0, "R1 no take while off", sample_take, 0);
        end
        wrapped = 0;
        tick();
        tx_enable = 1;
        target = sub_done + 4;
        while (sub_done < target) tick();
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (150000) @(posedge clk);
                chk(0, "watchdog", 0, 1);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule